// File: doc/BRIEF.md
# Single-Port SRAM FIFO Controller

This block builds a synchronous first-in first-out buffer on one external asynchronous SRAM that has a single port. A free-running slot sequencer splits memory time into a repeating five-cycle frame: a two-cycle read slot followed by a three-cycle write slot. The frame gives each user port one access every five clocks, which is 10 MHz at a 50 MHz memory clock.

Two address counters, one for writes and one for reads, are kept on chip. A registered multiplexer places one of them on the shared SRAM address bus, and only while an access is actually in progress. An up/down occupancy counter tracks the number of stored words, and the full and empty flags are decoded from it.

A push is parked in a one-word holding register until the next write slot. During that slot the write strobe falls only in the centre cycle. A pop is recorded as pending and served in the next read slot. Its data comes back with a one-cycle valid pulse. Requests that cannot be taken are dropped and reported with a pulse.

Sequencer states and transitions: `S_RD0 -> S_RD1` (read address and output enable settle), `S_RD1 -> S_WR0` (read data captured, write slot opens), `S_WR0 -> S_WR1` (strobe falls), `S_WR1 -> S_WR2` (strobe rises, data still held), `S_WR2 -> S_RD0` (write slot closes, read slot opens). Reset enters `S_RD0` with no access active.

Top module: `spfifo_ctrl`

## Requirements
- R1: After reset the sequencer repeats a fixed five-cycle frame: two read-slot cycles, then three write-slot cycles, starting with the first read cycle.
- R2: In a write slot that carries a word, `sram_we_n` is low for exactly one cycle, the middle one. During all three cycles of that slot `sram_addr` equals the write pointer and `sram_dq` carries the word.
- R3: In a write slot with no word to store, `sram_we_n` stays high and `sram_addr` keeps its previous value.
- R4: The write pointer and the read pointer each advance by one per completed access and wrap modulo 2^AW. A read slot that serves a pop presents the read pointer on `sram_addr` with `sram_oe_n` low.
- R5: The word count rises by one when a write slot completes and falls by one when a serviced read slot completes. `full` is high exactly when the count equals 2^AW, and `empty` is high exactly when it is zero.
- R6: A push is accepted when the FIFO is not full, the holding register is empty and no write slot is in progress. The word is stored in the next write slot.
- R7: A push that is not accepted changes nothing and produces a one-cycle `push_drop` pulse in the following cycle.
- R8: A pop is accepted when the FIFO is not empty and no pop is pending or being served. Words come out in push order. Each word appears on `pop_data` with a one-cycle `pop_valid` in the first write-slot cycle after the read slot that fetched it.
- R9: A pop that is not accepted produces a one-cycle `pop_drop` pulse in the following cycle and no `pop_valid`.
- R10: In reset and in the first cycle after it: `empty`=1, `full`=0, `sram_we_n`=1, `sram_oe_n`=1, and no pulse output is high.
- R11: The controller drives `sram_dq` only during the cycles of a write slot that carries a word. It never drives the bus while `sram_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; the user ports are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Request to append `push_data` |
| push_data | input | DW | Word to append |
| pop_req | input | 1 | Request to remove the oldest word |
| pop_data | output | DW | Word returned by a pop |
| pop_valid | output | 1 | One-cycle pulse marking `pop_data` |
| push_drop | output | 1 | Pulse: a push was refused |
| pop_drop | output | 1 | Pulse: a pop was refused |
| full | output | 1 | Occupancy equals 2^AW |
| empty | output | 1 | Occupancy is zero |
| sram_addr | output | AW | Shared SRAM address |
| sram_dq | inout | DW | SRAM data bus, tri-stated unless writing |
| sram_we_n | output | 1 | Active-low SRAM write strobe |
| sram_oe_n | output | 1 | Active-low SRAM output enable |

## Verification
The hardest case to reach from the ports is a request that lands in the single cycle where a slot hands over. Two examples are a push arriving at the edge where the holding register empties into the write slot, and a pop arriving while the last word is still being read. Either one can push the count past its bounds or read a word that has not been written. The stimulus holds requests high for long stretches and also issues them at random densities. Requests therefore land in every phase of the five-cycle frame, at every occupancy from empty to full and across pointer wrap. A behavioural queue model checks the flags, pulses, strobe and bus on every cycle.

// File: rtl/spf_pkg.sv
package spf_pkg;
    typedef enum logic [2:0] {
        S_RD0 = 3'd0,
        S_RD1 = 3'd1,
        S_WR0 = 3'd2,
        S_WR1 = 3'd3,
        S_WR2 = 3'd4
    } slot_t;
endpackage

// File: rtl/spf_slot_seq.sv
module spf_slot_seq
    import spf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_t state,
    output logic  rd_open,
    output logic  rd_close,
    output logic  wr_open,
    output logic  we_fall,
    output logic  we_rise,
    output logic  wr_close
);
    slot_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RD0;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = S_RD0;
        rd_open  = 1'b0;
        rd_close = 1'b0;
        wr_open  = 1'b0;
        we_fall  = 1'b0;
        we_rise  = 1'b0;
        wr_close = 1'b0;
        unique case (state)
            S_RD0: nxt = S_RD1;
            S_RD1: begin nxt = S_WR0; rd_close = 1'b1; wr_open = 1'b1; end
            S_WR0: begin nxt = S_WR1; we_fall = 1'b1; end
            S_WR1: begin nxt = S_WR2; we_rise = 1'b1; end
            S_WR2: begin nxt = S_RD0; wr_close = 1'b1; rd_open = 1'b1; end
            default: nxt = S_RD0;
        endcase
    end

    p_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR2) |=> (state == S_RD0));
endmodule

// File: rtl/spf_occupancy.sv
module spf_occupancy #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_done,
    input  logic          rd_done,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [AW:0]   count,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = AW + 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_done) wptr <= wptr + 1'b1;
            if (rd_done) rptr <= rptr + 1'b1;
            unique case ({wr_done, rd_done})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_comb begin
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
    end

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_no_wr_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_done);
    p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/spfifo_ctrl.sv
module spfifo_ctrl
    import spf_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] pop_data,
    output logic          pop_valid,
    output logic          push_drop,
    output logic          pop_drop,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] sram_addr,
    inout  wire  [DW-1:0] sram_dq,
    output logic          sram_we_n,
    output logic          sram_oe_n
);
    slot_t         state;
    logic          rd_open, rd_close, wr_open, we_fall, we_rise, wr_close;
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic          hold_v, wr_busy, pop_pend, rd_busy, dq_oe;
    logic [DW-1:0] hold_d, dq_out;
    logic          push_ok, pop_ok;

    spf_slot_seq u_seq (
        .clk(clk), .rst_n(rst_n), .state(state),
        .rd_open(rd_open), .rd_close(rd_close), .wr_open(wr_open),
        .we_fall(we_fall), .we_rise(we_rise), .wr_close(wr_close)
    );

    spf_occupancy #(.AW(AW)) u_occ (
        .clk(clk), .rst_n(rst_n),
        .wr_done(wr_close && wr_busy), .rd_done(rd_close && rd_busy),
        .wptr(wptr), .rptr(rptr), .count(count), .full(full), .empty(empty)
    );

    assign push_ok = push_req && !full && !hold_v && !wr_busy;
    assign pop_ok  = pop_req && !empty && !pop_pend && !rd_busy;
    assign sram_dq = dq_oe ? dq_out : {DW{1'bz}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_v    <= 1'b0;
            hold_d    <= '0;
            wr_busy   <= 1'b0;
            pop_pend  <= 1'b0;
            rd_busy   <= 1'b0;
            dq_oe     <= 1'b0;
            dq_out    <= '0;
            sram_addr <= '0;
            sram_we_n <= 1'b1;
            sram_oe_n <= 1'b1;
            pop_data  <= '0;
            pop_valid <= 1'b0;
            push_drop <= 1'b0;
            pop_drop  <= 1'b0;
        end else begin
            push_drop <= push_req && !push_ok;
            pop_drop  <= pop_req && !pop_ok;
            pop_valid <= 1'b0;
            // write slot
            if (wr_open) begin
                wr_busy <= hold_v;
                hold_v  <= 1'b0;
                if (hold_v) begin
                    sram_addr <= wptr;
                    dq_out    <= hold_d;
                    dq_oe     <= 1'b1;
                end
            end
            if (we_fall && wr_busy) sram_we_n <= 1'b0;
            if (we_rise)            sram_we_n <= 1'b1;
            if (wr_close) begin
                wr_busy <= 1'b0;
                dq_oe   <= 1'b0;
            end
            if (push_ok) begin
                hold_v <= 1'b1;
                hold_d <= push_data;
            end
            // read slot
            if (rd_open) begin
                rd_busy  <= pop_pend;
                pop_pend <= 1'b0;
                if (pop_pend) begin
                    sram_addr <= rptr;
                    sram_oe_n <= 1'b0;
                end
            end
            if (rd_close) begin
                rd_busy   <= 1'b0;
                sram_oe_n <= 1'b1;
                if (rd_busy) begin
                    pop_valid <= 1'b1;
                    pop_data  <= sram_dq;
                end
            end
            if (pop_ok) pop_pend <= 1'b1;
        end
    end

    p_strobe_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (state == S_WR1));
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |=> sram_we_n);
    p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && state != S_WR0) |-> $stable(sram_addr));
    p_idle_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR1 && !dq_oe) |-> ($stable(sram_addr) && sram_we_n));
    p_bus_conflict_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && !sram_oe_n));
    p_valid_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> (state == S_WR0));
endmodule

// File: tb/sim_spfifo_ctrl.sv
module sim_spfifo_ctrl;
    localparam int CLK_PERIOD = 20;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int D  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_req = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          pop_req = 1'b0;
    logic [DW-1:0] pop_data;
    logic          pop_valid, push_drop, pop_drop, full, empty;
    logic [AW-1:0] sram_addr;
    wire  [DW-1:0] sram_dq;
    logic          sram_we_n, sram_oe_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spfifo_ctrl #(.DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
        .push_drop(push_drop), .pop_drop(pop_drop), .full(full), .empty(empty),
        .sram_addr(sram_addr), .sram_dq(sram_dq),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    // behavioural asynchronous SRAM
    logic [DW-1:0] mem [D];
    assign sram_dq = (!sram_oe_n && sram_we_n) ? mem[sram_addr] : {DW{1'bz}};
    always @(posedge sram_we_n) if (rst_n) mem[sram_addr] = sram_dq;

    // reference model: queue plus frame phase
    logic [DW-1:0] q[$];
    int ph, cnt, wp, rp;
    bit hv, wb, pp, rb;
    logic [DW-1:0] hd, wd, ed;
    bit ev, epd, eod;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            q.delete(); ph = 0; cnt = 0; wp = 0; rp = 0;
            hv = 0; wb = 0; pp = 0; rb = 0; ev = 0; epd = 0; eod = 0;
        end else begin
            bit ap, ao;
            ap = push_req && cnt != D && !hv && !wb;
            ao = pop_req && cnt != 0 && !pp && !rb;
            epd = push_req && !ap;
            eod = pop_req && !ao;
            ev = 0;
            if (ph == 1) begin
                if (rb) begin ev = 1; ed = q.pop_front(); cnt--; rp = (rp + 1) % D; end
                rb = 0;
                wb = hv; wd = hd; hv = 0;
            end
            if (ph == 4) begin
                if (wb) begin q.push_back(wd); cnt++; wp = (wp + 1) % D; end
                wb = 0;
                rb = pp; pp = 0;
            end
            if (ap) begin hv = 1; hd = push_data; end
            if (ao) pp = 1;
            ph = (ph + 1) % 5;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    logic [AW-1:0] prev_addr = '0;

    task automatic compare();
        chk(full == (cnt == D), "R5 full", int'(full), int'(cnt == D));
        chk(empty == (cnt == 0), "R5 empty", int'(empty), int'(cnt == 0));
        chk(push_drop == epd, "R7 push_drop", int'(push_drop), int'(epd));
        chk(pop_drop == eod, "R9 pop_drop", int'(pop_drop), int'(eod));
        chk(pop_valid == ev, "R8 pop_valid", int'(pop_valid), int'(ev));
        if (ev) chk(pop_data == ed, "R8 pop_data order", int'(pop_data), int'(ed));
        chk(sram_we_n == !(ph == 3 && wb), "R2 strobe middle cycle", int'(sram_we_n), int'(!(ph == 3 && wb)));
        if (ph >= 2 && wb) begin
            chk(sram_addr == AW'(wp), "R2 R4 write address", int'(sram_addr), wp);
            chk(sram_dq == wd, "R2 R11 write data driven", int'(sram_dq), int'(wd));
        end
        if (ph >= 2 && !wb)
            chk(sram_addr == prev_addr, "R3 idle slot address", int'(sram_addr), int'(prev_addr));
        if (ph == 1 && rb) begin
            chk(sram_addr == AW'(rp), "R4 read address", int'(sram_addr), rp);
            chk(sram_oe_n == 1'b0, "R4 output enable", int'(sram_oe_n), 0);
        end
        if (ph <= 1) chk(sram_we_n == 1'b1, "R1 no strobe in read slot", int'(sram_we_n), 1);
        prev_addr = sram_addr;
    endtask

    task automatic run(input int n, input int push_pct, input int pop_pct);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            push_req  = ($urandom_range(99) < push_pct);
            push_data = DW'($urandom);
            pop_req   = ($urandom_range(99) < pop_pct);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(empty == 1'b1, "R10 empty in reset", int'(empty), 1);
        chk(full == 1'b0, "R10 full in reset", int'(full), 0);
        chk(sram_we_n && sram_oe_n, "R10 strobes idle", int'({sram_we_n, sram_oe_n}), 3);
        chk(!(pop_valid || push_drop || pop_drop), "R10 pulses low", int'({pop_valid, push_drop, pop_drop}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(empty && !full && sram_we_n && sram_oe_n && !pop_valid, "R10 first cycle", int'(empty), 1);
        prev_addr = sram_addr;
        run(40, 0, 100);     // R9 pops on empty
        run(160, 100, 0);    // R6 fill, R7 pushes on full
        run(160, 0, 100);    // R8 drain in order, R9 underflow
        run(200, 30, 30);    // sparse mixed
        run(2000, 60, 50);   // mixed, pointer wrap R4
        run(300, 100, 100);  // both every cycle
        run(400, 90, 10);    // drift to full
        run(400, 10, 90);    // drift to empty
        push_req = 0; pop_req = 0;
        run(20, 0, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule